// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block is the architectural register store of a 32-bit processor core. Sixteen registers are visible at any moment, r0 to r15, with r15 acting as the program counter. The physical register behind a register number depends on the operating mode held in the current status word. The fast-interrupt mode has private copies of r8 through r14. The other exception modes have private copies of r13 and r14 only. User and system modes share one set. Each exception mode also owns a saved status word.

Two combinational read ports and one write port are addressed by a 4-bit register number, which is resolved through the current mode. An exception request names an exception kind. In a single clock edge the block stores the return address in the target mode's r14, copies the current status word into the target's saved status word, switches mode, masks interrupts and loads the vector address. A branch-exchange write sets or clears the instruction-set state bit and redirects the program counter. The core's decoder drives all of these inputs; it sees the results on the read ports and on the status and program-counter outputs.

Top module: `bank_regfile`

## Requirements
- R1: After reset the mode is supervisor, interrupt masks I (bit 7) and F (bit 6) are set, the state bit T (bit 5), the flags N,Z,C,V,Q (bits 31..27), the program counter and all saved status words are zero, so the status word reads 0x000000D3. The mode field is bits 4..0, with codes user 0x10, fast interrupt 0x11, normal interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F.
- R2: Registers r0 to r7 are one shared copy in every mode, and reading register 15 on either read port returns the current program counter.
- R3: In fast-interrupt mode, r8 to r14 name private copies that writes in other modes do not touch.
- R4: In normal-interrupt, supervisor, abort and undefined modes, r13 and r14 are private to each mode while r8 to r12 are the shared copies.
- R5: User and system modes see the same physical r0 to r14.
- R6: An exception request with kind 0 (undefined), 1 (supervisor call), 2 (abort), 3 (normal interrupt) or 4 (fast interrupt) writes the program counter into the target mode's r14, switches the mode, and loads the vector for that kind (defaults 0x04, 0x08, 0x10, 0x18, 0x1C) on the next clock. Kinds 5 to 7 are ignored.
- R7: On exception entry the current status word is copied into the target mode's saved status word in the same cycle. The saved-status output shows the word of the current mode, and a saved-status write in an exception mode updates that mode's word.
- R8: Exception entry sets I and clears T. F is set only on fast-interrupt entry and is otherwise left unchanged.
- R9: A branch-exchange write copies bit 0 of its operand into T and loads the program counter with the operand's bit 0 cleared.
- R10: In user and system modes the saved-status output reads zero and saved-status writes are ignored.
- R11: When a register write falls in the same cycle as an exception entry, a write to r14 or r15 is dropped. A write to any other register completes in the bank of the mode that was current before the switch.
- R12: A write to register 15 loads the program counter with bit 0 cleared on the next clock. A branch-exchange write in the same cycle takes precedence.
- R13: A status-word write replaces the whole word, mode included. Exception entry overrides it, and a branch-exchange write in the same cycle still sets T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| bx_en | input | 1 | Branch-exchange write strobe |
| bx_data | input | 32 | Branch-exchange operand |
| cpsr_wr_en | input | 1 | Current status word write enable |
| cpsr_wr_data | input | 32 | Current status word write data |
| spsr_wr_en | input | 1 | Saved status word write enable |
| spsr_wr_data | input | 32 | Saved status word write data |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception kind 0..4 |
| pc_out | output | 32 | Current program counter |
| cpsr_out | output | 32 | Current status word |
| spsr_out | output | 32 | Saved status word of the current mode |

## Verification
Every cycle, the bound checker confirms several properties. An exception entry always lands in the matching mode with I set and T clear, F is set after fast-interrupt entry, the saved status word seen afterwards equals the status word before entry, and r14 read in the first cycle after entry holds the old program counter. It also confirms that branch-exchange and r15 writes redirect the program counter and T as required, and that user and system modes always show a zero saved status word. The bench alone can show that the banks are separate. It writes r8 to r14 in all seven modes and reads back in each mode to see which copies are shared and which are private. It also covers the same-cycle collisions between a write and an exception entry, the vector values, and the ignored exception kinds.

// File: rtl/bank_pkg.sv
package bank_pkg;

  typedef enum logic [4:0] {
    M_USR = 5'h10,
    M_FIQ = 5'h11,
    M_IRQ = 5'h12,
    M_SVC = 5'h13,
    M_ABT = 5'h17,
    M_UND = 5'h1B,
    M_SYS = 5'h1F
  } mode_e;

  typedef enum logic [2:0] {
    EX_UND = 3'd0,
    EX_SVC = 3'd1,
    EX_ABT = 3'd2,
    EX_IRQ = 3'd3,
    EX_FIQ = 3'd4
  } exc_e;

  // stack/link banks: 0 shared user/system, 1 fast irq, 2..5 other exception modes
  localparam int NBANK = 6;
  localparam int NSPSR = NBANK - 1;

  localparam int SB_I = 7;
  localparam int SB_F = 6;
  localparam int SB_T = 5;

  function automatic logic [2:0] bank_of(logic [4:0] m);
    case (m)
      M_FIQ:   bank_of = 3'd1;
      M_IRQ:   bank_of = 3'd2;
      M_SVC:   bank_of = 3'd3;
      M_ABT:   bank_of = 3'd4;
      M_UND:   bank_of = 3'd5;
      default: bank_of = 3'd0;
    endcase
  endfunction

  function automatic logic exc_valid(logic [2:0] k);
    exc_valid = (k <= EX_FIQ);
  endfunction

  function automatic logic [4:0] mode_of_exc(logic [2:0] k);
    case (k)
      EX_UND:  mode_of_exc = M_UND;
      EX_SVC:  mode_of_exc = M_SVC;
      EX_ABT:  mode_of_exc = M_ABT;
      EX_IRQ:  mode_of_exc = M_IRQ;
      default: mode_of_exc = M_FIQ;
    endcase
  endfunction

endpackage

// File: rtl/bank_map.sv
// Resolves an architectural register number to a physical slot.
// Slot layout: [0, NSHARED) shared r0..r12, then fast-irq r8..r12,
// then one r13/r14 pair per bank.
module bank_map
  import bank_pkg::*;
#(
  parameter int NSHARED = 13,
  parameter int FIQ_LO  = 8,
  parameter int PW      = 5
) (
  input  logic [4:0]    mode,
  input  logic [3:0]    idx,
  output logic [PW-1:0] phys
);
  localparam int FIQ_BASE  = NSHARED;
  localparam int NFIQ      = NSHARED - FIQ_LO;
  localparam int LINK_BASE = FIQ_BASE + NFIQ;

  logic [2:0] bank;

  always_comb begin
    bank = bank_of(mode);
    if (int'(idx) >= NSHARED) begin
      phys = PW'(LINK_BASE + 2 * int'(bank) + ((idx == 4'd14) ? 1 : 0));
    end else if (bank == 3'd1 && int'(idx) >= FIQ_LO) begin
      phys = PW'(FIQ_BASE + int'(idx) - FIQ_LO);
    end else begin
      phys = PW'(idx);
    end
  end

endmodule

// File: rtl/bank_store.sv
// Physical register array: one general write port, one link write port
// (link port wins on the same slot), two asynchronous read ports.
module bank_store #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 30,
  parameter int PW    = 5
) (
  input  logic            clk,
  input  logic            we_g,
  input  logic [PW-1:0]   wa_g,
  input  logic [XLEN-1:0] wd_g,
  input  logic            we_l,
  input  logic [PW-1:0]   wa_l,
  input  logic [XLEN-1:0] wd_l,
  input  logic [PW-1:0]   ra0,
  output logic [XLEN-1:0] rd0,
  input  logic [PW-1:0]   ra1,
  output logic [XLEN-1:0] rd1
);
  logic [NPHYS-1:0][XLEN-1:0] view;

  for (genvar i = 0; i < NPHYS; i++) begin : g_ent
    logic            hit_g, hit_l, en;
    logic [XLEN-1:0] q, d;

    assign hit_g = we_g && (wa_g == PW'(i));
    assign hit_l = we_l && (wa_l == PW'(i));
    assign en    = hit_g || hit_l;

    always_comb begin
      d = hit_l ? wd_l : wd_g;
    end

    // data storage carries no reset
    always_ff @(posedge clk) begin
      if (en) q <= d;
    end

    assign view[i] = q;
  end

  assign rd0 = (int'(ra0) < NPHYS) ? view[ra0] : '0;
  assign rd1 = (int'(ra1) < NPHYS) ? view[ra1] : '0;

endmodule

// File: rtl/status_unit.sv
// Current status word, saved status words and program counter.
module status_unit
  import bank_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] VEC_UND = 'h04,
  parameter logic [XLEN-1:0] VEC_SVC = 'h08,
  parameter logic [XLEN-1:0] VEC_ABT = 'h10,
  parameter logic [XLEN-1:0] VEC_IRQ = 'h18,
  parameter logic [XLEN-1:0] VEC_FIQ = 'h1C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_take,
  input  logic [2:0]      exc_kind,
  input  logic            bx_en,
  input  logic [XLEN-1:0] bx_data,
  input  logic            cpsr_we,
  input  logic [XLEN-1:0] cpsr_wd,
  input  logic            spsr_we,
  input  logic [XLEN-1:0] spsr_wd,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_wd,
  output logic [XLEN-1:0] cpsr_q,
  output logic [XLEN-1:0] spsr_cur,
  output logic [XLEN-1:0] pc_q
);
  localparam logic [XLEN-1:0] CPSR_RST =
      XLEN'((1 << SB_I) | (1 << SB_F) | int'(M_SVC));

  logic [XLEN-1:0] spsr_q [NSPSR];
  logic [XLEN-1:0] spsr_d [NSPSR];
  logic [XLEN-1:0] cpsr_d, pc_d, vec;
  logic [2:0]      cur_bank, tgt_bank, cur_slot, tgt_slot;
  logic            cpsr_en, pc_en, spsr_en;

  always_comb begin
    case (exc_kind)
      EX_UND:  vec = VEC_UND;
      EX_SVC:  vec = VEC_SVC;
      EX_ABT:  vec = VEC_ABT;
      EX_IRQ:  vec = VEC_IRQ;
      default: vec = VEC_FIQ;
    endcase
  end

  assign cur_bank = bank_of(cpsr_q[4:0]);
  assign tgt_bank = bank_of(mode_of_exc(exc_kind));
  assign cur_slot = cur_bank - 3'd1;
  assign tgt_slot = tgt_bank - 3'd1;

  always_comb begin
    cpsr_d = cpsr_q;
    pc_d   = pc_q;
    spsr_d = spsr_q;
    if (cpsr_we) cpsr_d = cpsr_wd;
    if (pc_we)   pc_d   = {pc_wd[XLEN-1:1], 1'b0};
    if (bx_en) begin
      cpsr_d[SB_T] = bx_data[0];
      pc_d         = {bx_data[XLEN-1:1], 1'b0};
    end
    if (spsr_we && cur_bank != 3'd0) spsr_d[cur_slot] = spsr_wd;
    if (exc_take) begin
      spsr_d[tgt_slot] = cpsr_q;
      cpsr_d           = cpsr_q;
      cpsr_d[4:0]      = mode_of_exc(exc_kind);
      cpsr_d[SB_I]     = 1'b1;
      cpsr_d[SB_T]     = 1'b0;
      if (exc_kind == EX_FIQ) cpsr_d[SB_F] = 1'b1;
      pc_d             = vec;
    end
  end

  assign cpsr_en = cpsr_we || bx_en || exc_take;
  assign pc_en   = pc_we || bx_en || exc_take;
  assign spsr_en = spsr_we || exc_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q <= CPSR_RST;
      pc_q   <= '0;
      for (int i = 0; i < NSPSR; i++) spsr_q[i] <= '0;
    end else begin
      if (cpsr_en) cpsr_q <= cpsr_d;
      if (pc_en)   pc_q   <= pc_d;
      if (spsr_en) spsr_q <= spsr_d;
    end
  end

  assign spsr_cur = (cur_bank == 3'd0) ? '0 : spsr_q[cur_slot];

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] VEC_UND = 'h04,
  parameter logic [XLEN-1:0] VEC_SVC = 'h08,
  parameter logic [XLEN-1:0] VEC_ABT = 'h10,
  parameter logic [XLEN-1:0] VEC_IRQ = 'h18,
  parameter logic [XLEN-1:0] VEC_FIQ = 'h1C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            bx_en,
  input  logic [XLEN-1:0] bx_data,
  input  logic            cpsr_wr_en,
  input  logic [XLEN-1:0] cpsr_wr_data,
  input  logic            spsr_wr_en,
  input  logic [XLEN-1:0] spsr_wr_data,
  input  logic            exc_req,
  input  logic [2:0]      exc_kind,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] cpsr_out,
  output logic [XLEN-1:0] spsr_out
);
  localparam int NSHARED = 13;
  localparam int FIQ_LO  = 8;
  localparam int NPHYS   = NSHARED + (NSHARED - FIQ_LO) + 2 * NBANK;
  localparam int PW      = $clog2(NPHYS);
  localparam int NMAP    = 4;  // read A, read B, write, link
  localparam int PC_IDX  = 15;
  localparam int LR_IDX  = 14;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic            exc_take, gpr_we, pc_we;
  logic [4:0]      cur_mode, tgt_mode;
  logic [XLEN-1:0] cpsr_q, pc_q, rdat_a, rdat_b;

  logic [4:0]    map_mode [NMAP];
  logic [3:0]    map_idx  [NMAP];
  logic [PW-1:0] map_phys [NMAP];

  assign exc_take = exc_req && exc_valid(exc_kind);
  assign cur_mode = cpsr_q[4:0];
  assign tgt_mode = mode_of_exc(exc_kind);

  assign map_mode[0] = cur_mode;  assign map_idx[0] = rd_a_idx;
  assign map_mode[1] = cur_mode;  assign map_idx[1] = rd_b_idx;
  assign map_mode[2] = cur_mode;  assign map_idx[2] = wr_idx;
  assign map_mode[3] = tgt_mode;  assign map_idx[3] = 4'(LR_IDX);

  for (genvar p = 0; p < NMAP; p++) begin : g_map
    bank_map #(.NSHARED(NSHARED), .FIQ_LO(FIQ_LO), .PW(PW)) u_map (
      .mode (map_mode[p]),
      .idx  (map_idx[p]),
      .phys (map_phys[p])
    );
  end

  assign gpr_we = wr_en && (wr_idx != 4'(PC_IDX))
                  && !(exc_take && wr_idx == 4'(LR_IDX));
  assign pc_we  = wr_en && (wr_idx == 4'(PC_IDX));

  bank_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW)) u_store (
    .clk  (clk),
    .we_g (gpr_we),
    .wa_g (map_phys[2]),
    .wd_g (wr_data),
    .we_l (exc_take),
    .wa_l (map_phys[3]),
    .wd_l (pc_q),
    .ra0  (map_phys[0]),
    .rd0  (rdat_a),
    .ra1  (map_phys[1]),
    .rd1  (rdat_b)
  );

  status_unit #(
    .XLEN(XLEN), .VEC_UND(VEC_UND), .VEC_SVC(VEC_SVC),
    .VEC_ABT(VEC_ABT), .VEC_IRQ(VEC_IRQ), .VEC_FIQ(VEC_FIQ)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .exc_take (exc_take),
    .exc_kind (exc_kind),
    .bx_en    (bx_en),
    .bx_data  (bx_data),
    .cpsr_we  (cpsr_wr_en),
    .cpsr_wd  (cpsr_wr_data),
    .spsr_we  (spsr_wr_en),
    .spsr_wd  (spsr_wr_data),
    .pc_we    (pc_we),
    .pc_wd    (wr_data),
    .cpsr_q   (cpsr_q),
    .spsr_cur (spsr_out),
    .pc_q     (pc_q)
  );

  assign rd_a_data = (rd_a_idx == 4'(PC_IDX)) ? pc_q : rdat_a;
  assign rd_b_data = (rd_b_idx == 4'(PC_IDX)) ? pc_q : rdat_b;
  assign pc_out    = pc_q;
  assign cpsr_out  = cpsr_q;

endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk
  import bank_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic        bx_en,
  input logic [31:0] bx_data,
  input logic        exc_req,
  input logic [2:0]  exc_kind,
  input logic [31:0] pc_out,
  input logic [31:0] cpsr_out,
  input logic [31:0] spsr_out
);
  logic took;
  assign took = exc_req && (exc_kind <= 3'd4);

  p_exc_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> cpsr_out[4:0] == mode_of_exc($past(exc_kind)));

  p_exc_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (took ##1 (rd_a_idx == 4'd14)) |-> rd_a_data == $past(pc_out));

  p_spsr_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> spsr_out == $past(cpsr_out));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> cpsr_out[7] && !cpsr_out[5]);

  p_fiq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (took && exc_kind == 3'd4) |=> cpsr_out[6]);

  p_bx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_en && !took) |=> (cpsr_out[5] == $past(bx_data[0]))
                          && (pc_out == {$past(bx_data[31:1]), 1'b0}));

  p_spsr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_out[4:0] == 5'h10 || cpsr_out[4:0] == 5'h1F) |-> spsr_out == 32'h0);

  p_pc_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15 && !bx_en && !took)
      |=> pc_out == {$past(wr_data[31:1]), 1'b0});

endmodule

bind bank_regfile bank_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .bx_en     (bx_en),
  .bx_data   (bx_data),
  .exc_req   (exc_req),
  .exc_kind  (exc_kind),
  .pc_out    (pc_out),
  .cpsr_out  (cpsr_out),
  .spsr_out  (spsr_out)
);

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
module bank_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, bx_data, cpsr_wr_data, spsr_wr_data;
  logic        wr_en, bx_en, cpsr_wr_en, spsr_wr_en, exc_req;
  logic [2:0]  exc_kind;
  logic [31:0] pc_out, cpsr_out, spsr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bank_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .bx_en(bx_en), .bx_data(bx_data),
    .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data),
    .exc_req(exc_req), .exc_kind(exc_kind),
    .pc_out(pc_out), .cpsr_out(cpsr_out), .spsr_out(spsr_out)
  );

  localparam logic [4:0] MUSR = 5'h10, MFIQ = 5'h11, MIRQ = 5'h12,
                         MSVC = 5'h13, MABT = 5'h17, MUND = 5'h1B, MSYS = 5'h1F;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en = 0; bx_en = 0; cpsr_wr_en = 0; spsr_wr_en = 0; exc_req = 0;
  endtask

  task automatic put_cpsr(logic [31:0] v);
    cpsr_wr_en = 1; cpsr_wr_data = v; step(); idle();
  endtask

  task automatic set_mode(logic [4:0] m);
    put_cpsr(32'h000000C0 | 32'(m));
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] v);
    wr_en = 1; wr_idx = i; wr_data = v; step(); idle();
  endtask

  task automatic rd(logic [3:0] i, output logic [31:0] v);
    rd_a_idx = i; #1; v = rd_a_data;
  endtask

  task automatic exc(logic [2:0] k);
    exc_req = 1; exc_kind = k; step(); idle();
  endtask

  task automatic t_reset();
    #1;
    check("R1 status word", cpsr_out, 32'h000000D3);
    check("R1 pc", pc_out, 32'h0);
    check("R1 saved status", spsr_out, 32'h0);
  endtask

  function automatic logic [31:0] bval(int m, int i);
    return 32'(m * 256 + i);
  endfunction

  task automatic t_banks();
    logic [4:0]  ml [7] = '{MUSR, MFIQ, MIRQ, MSVC, MABT, MUND, MSYS};
    logic [31:0] v;
    for (int m = 0; m < 7; m++) begin
      set_mode(ml[m]);
      for (int i = 8; i <= 14; i++) wr(4'(i), bval(m, i));
    end
    for (int m = 0; m < 7; m++) begin
      set_mode(ml[m]);
      for (int i = 8; i <= 14; i++) begin
        rd(4'(i), v);
        if (i <= 12) begin
          if (m == 1) check("R3 fiq private r8-r12", v, bval(1, i));
          else        check("R4 shared r8-r12", v, bval(6, i));
        end else if (m == 0 || m == 6) begin
          check("R5 user/system share r13-r14", v, bval(6, i));
        end else begin
          check("R4 private r13-r14", v, bval(m, i));
        end
      end
    end
    set_mode(MFIQ);
    for (int i = 0; i < 8; i++) wr(4'(i), 32'hA000 + 32'(i));
    set_mode(MUND);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v);
      check("R2 shared r0-r7", v, 32'hA000 + 32'(i));
    end
    wr(4'd15, 32'h00000ABD);
    rd(4'd15, v);
    check("R2 r15 reads pc port A", v, 32'h00000ABC);
    rd_b_idx = 4'd15; #1;
    check("R2 r15 reads pc port B", rd_b_data, 32'h00000ABC);
    rd_b_idx = 4'd3; #1;
    check("R2 port B general", rd_b_data, 32'hA003);
  endtask

  task automatic t_exception();
    logic [31:0] v;
    put_cpsr(32'hA0000010);
    check("R13 status write", cpsr_out, 32'hA0000010);
    wr(4'd15, 32'h00001000);
    check("R12 pc write", pc_out, 32'h00001000);
    exc(3'd1);
    check("R6 R8 svc entry status", cpsr_out, 32'hA0000093);
    check("R6 svc vector", pc_out, 32'h08);
    check("R7 svc saved status", spsr_out, 32'hA0000010);
    rd(4'd14, v);
    check("R6 svc link", v, 32'h00001000);
    exc(3'd4);
    check("R6 R8 fiq entry status", cpsr_out, 32'hA00000D1);
    check("R6 fiq vector", pc_out, 32'h1C);
    check("R7 fiq saved status", spsr_out, 32'hA0000093);
    rd(4'd14, v);
    check("R6 fiq link", v, 32'h08);
    exc(3'd5);
    check("R6 kind 5 ignored status", cpsr_out, 32'hA00000D1);
    check("R6 kind 5 ignored pc", pc_out, 32'h1C);
    exc(3'd7);
    check("R6 kind 7 ignored pc", pc_out, 32'h1C);
    exc(3'd0);
    check("R6 und vector", pc_out, 32'h04);
    exc(3'd2);
    check("R6 abt vector", pc_out, 32'h10);
    check("R6 abt mode", {27'h0, cpsr_out[4:0]}, 32'h17);
    exc(3'd3);
    check("R6 irq vector", pc_out, 32'h18);
    check("R8 F kept on irq entry", {31'h0, cpsr_out[6]}, 32'h1);
    cpsr_wr_en = 1; cpsr_wr_data = 32'h00000010; exc_req = 1; exc_kind = 3'd0;
    step(); idle();
    check("R13 entry overrides status write", cpsr_out[7:0], 8'hDB);
  endtask

  task automatic t_bx();
    set_mode(MUSR);
    bx_en = 1; bx_data = 32'h00002001; step(); idle();
    check("R9 T set", {31'h0, cpsr_out[5]}, 32'h1);
    check("R9 pc from bx", pc_out, 32'h00002000);
    bx_en = 1; bx_data = 32'h00003000; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h9998;
    step(); idle();
    check("R9 T cleared", {31'h0, cpsr_out[5]}, 32'h0);
    check("R12 bx beats r15 write", pc_out, 32'h00003000);
    bx_en = 1; bx_data = 32'h1; cpsr_wr_en = 1; cpsr_wr_data = 32'h40000010;
    step(); idle();
    check("R13 bx sets T with status write", cpsr_out, 32'h40000030);
    set_mode(MUSR);
    exc_req = 1; exc_kind = 3'd1; bx_en = 1; bx_data = 32'h5001; step(); idle();
    check("R8 entry clears T over bx", {31'h0, cpsr_out[5]}, 32'h0);
  endtask

  task automatic t_spsr();
    logic [31:0] keep;
    set_mode(MSVC);
    spsr_wr_en = 1; spsr_wr_data = 32'h12345678; step(); idle();
    check("R7 svc saved status write", spsr_out, 32'h12345678);
    set_mode(MUSR);
    check("R10 user reads zero", spsr_out, 32'h0);
    spsr_wr_en = 1; spsr_wr_data = 32'hFFFFFFFF; step(); idle();
    check("R10 user write ignored", spsr_out, 32'h0);
    set_mode(MSYS);
    spsr_wr_en = 1; spsr_wr_data = 32'hFFFFFFFF; step(); idle();
    check("R10 system reads zero", spsr_out, 32'h0);
    set_mode(MSVC);
    keep = spsr_out;
    check("R10 svc saved status untouched", keep, 32'h12345678);
  endtask

  task automatic t_collide();
    logic [31:0] v, old14;
    set_mode(MSVC);
    wr(4'd15, 32'h00004000);
    wr(4'd14, 32'h0000C0DE);
    exc_req = 1; exc_kind = 3'd3; wr_en = 1; wr_idx = 4'd13; wr_data = 32'h0000BEEF;
    step(); idle();
    check("R11 irq entry taken", {27'h0, cpsr_out[4:0]}, 32'h12);
    rd(4'd13, v);
    check("R11 irq r13 untouched", v, bval(2, 13));
    set_mode(MSVC);
    rd(4'd13, v);
    check("R11 r13 write lands in old bank", v, 32'h0000BEEF);
    wr(4'd15, 32'h00004000);
    rd(4'd14, old14);
    exc_req = 1; exc_kind = 3'd2; wr_en = 1; wr_idx = 4'd14; wr_data = 32'h5555;
    step(); idle();
    rd(4'd14, v);
    check("R11 abt link wins", v, 32'h00004000);
    set_mode(MSVC);
    rd(4'd14, v);
    check("R11 r14 write dropped", v, old14);
    exc_req = 1; exc_kind = 3'd0; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h7776;
    step(); idle();
    check("R11 r15 write dropped", pc_out, 32'h04);
  endtask

  initial begin
    rst_n = 0; idle();
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; bx_data = 0;
    cpsr_wr_data = 0; spsr_wr_data = 0; exc_kind = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) step();
    t_reset();
    t_banks();
    t_exception();
    t_bx();
    t_spsr();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule